// File: doc/BRIEF.md
# Two-Result 40-bit Vector Lane ALU

This block is one lane of a SIMD arithmetic and logic datapath. Each cycle it may accept one operation, chosen by a 5-bit opcode, together with up to three 40-bit source values. It returns one or two 40-bit results. The operation set covers arithmetic (sums, differences, absolute values, a three-term add, and an add of a sign-extended top byte), bitwise logic, signed compares, narrow min/max and a sorted pair, a shift whose direction follows the sign of its amount, a shift that rounds to nearest, and a select.

Most operations are combinational, and their result appears in the cycle they are issued. A fixed group of "one-slot" operations is instead captured in an output register, so their result appears in the following cycle (parameter `REG_SLOW`, on by default). Operand hazards and scheduling belong to the surrounding pipeline. When a registered result and a new combinational result fall in the same cycle, this lane applies a fixed precedence.

Top module: `vlane_alu`

## Requirements
- R1: Opcodes ADD (1), SUB (2) and ADDSUB (24) wrap modulo 2^40. ADD gives src1+src2 and SUB gives src1-src2 on dst1. ADDSUB gives src1+src2 on dst1 and src1-src2 on dst2.
- R2: ABSDIF (3) gives |src1-src2|, using a 41-bit signed difference truncated to 40 bits. ABS (26) gives |src1| (wraps) and ADD3 (16) gives src1+src2+src3. ADIF3 (17) gives src1-src2+src3 and SAD (18) gives src3+|src1-src2|. ADDH (25) gives src1 plus src2[39:32] sign-extended. All of these are on dst1, modulo 2^40.
- R3: The bitwise ops put their result on dst1: AND (4), OR (5), XOR (6), ANDN (7, src1 & ~src2), NOT (8, ~src1), AND3 (20) and OR3 (21, three-way).
- R4: SEL (19) puts src2 on dst1 when src1 is nonzero, and src3 otherwise.
- R5: CMPEQ (13), CMPGT (14) and CMPGE (15) compare src1 with src2 as signed 40-bit values. dst1 is 1 when the relation holds and 0 otherwise.
- R6: MIN (9) and MAX (10) read src1[32:0] and src2[32:0] as signed 33-bit values and return the result sign-extended to 40 bits on dst1. SORT2 (23) returns the minimum on dst1 and the maximum on dst2.
- R7: SHF (11) reads src2[5:0] as a signed amount. A non-negative amount k shifts src1 left by k. A negative amount shifts src1 right arithmetically by -k. A magnitude of 40 or more gives 0 for a left shift and all sign bits for a right shift. SHFOR (22) gives src3 OR that shifted value.
- R8: RND (12) reads n = src2[4:0] and gives (src1 + 2^(n-1)) >> n, with an arithmetic shift computed without intermediate overflow. When n = 0 it passes src1 through.
- R9: RND, ADD3, ADIF3, SAD, AND3, OR3 and SHFOR are one-slot operations. Their result appears with o_valid=1 and o_late=1 in the cycle after issue. All other defined ops present their result in the issue cycle with o_late=0.
- R10: If a one-slot result is due in the same cycle as a newly issued zero-slot op, the one-slot result is presented and the new op produces no output.
- R11: When nothing is due, o_valid=0 and both dst outputs are 0. This covers i_valid low, NOP (0), undefined codes 27 to 31, and reset. Operations with a single result drive dst2 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the one-slot result register |
| i_valid | input | 1 | An operation is issued this cycle |
| i_op | input | 5 | Opcode |
| i_src1 | input | 40 | First source operand |
| i_src2 | input | 40 | Second source operand |
| i_src3 | input | 40 | Third source operand |
| o_valid | output | 1 | dst outputs carry a result |
| o_late | output | 1 | The result shown comes from a one-slot op issued in the previous cycle |
| o_dst1 | output | 40 | First result |
| o_dst2 | output | 40 | Second result (0 for single-result ops) |

## Verification
A zero-slot result is due in its issue cycle. The bench drives operands on the falling edge and samples one time unit later, before the next rising edge. A one-slot result is due after the rising edge that follows issue. For these ops the bench lets that edge pass, drives an idle cycle with scrambled operands, and samples inside it, which also shows that later inputs cannot disturb the held result. For the precedence case, a zero-slot op is issued in that same cycle, and the following cycle is checked for the absence of any output.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  typedef enum logic [4:0] {
    OP_NOP    = 5'd0,
    OP_ADD    = 5'd1,
    OP_SUB    = 5'd2,
    OP_ABSDIF = 5'd3,
    OP_AND    = 5'd4,
    OP_OR     = 5'd5,
    OP_XOR    = 5'd6,
    OP_ANDN   = 5'd7,
    OP_NOT    = 5'd8,
    OP_MIN    = 5'd9,
    OP_MAX    = 5'd10,
    OP_SHF    = 5'd11,
    OP_RND    = 5'd12,
    OP_CMPEQ  = 5'd13,
    OP_CMPGT  = 5'd14,
    OP_CMPGE  = 5'd15,
    OP_ADD3   = 5'd16,
    OP_ADIF3  = 5'd17,
    OP_SAD    = 5'd18,
    OP_SEL    = 5'd19,
    OP_AND3   = 5'd20,
    OP_OR3    = 5'd21,
    OP_SHFOR  = 5'd22,
    OP_SORT2  = 5'd23,
    OP_ADDSUB = 5'd24,
    OP_ADDH   = 5'd25,
    OP_ABS    = 5'd26
  } vl_op_e;

  // One-slot ops: result is registered and appears a cycle later
  function automatic logic op_is_slow(input vl_op_e op);
    case (op)
      OP_RND, OP_ADD3, OP_ADIF3, OP_SAD,
      OP_AND3, OP_OR3, OP_SHFOR: return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_known(input vl_op_e op);
    return (op != OP_NOP) && (op <= OP_ABS);
  endfunction

  function automatic logic op_is_cmp(input vl_op_e op);
    return (op == OP_CMPEQ) || (op == OP_CMPGT) || (op == OP_CMPGE);
  endfunction

endpackage

// File: rtl/vlane_arith.sv
module vlane_arith
  import vlane_pkg::*;
#(
  parameter int DW  = 40,
  parameter int RSW = 5,
  parameter int HIW = 8
) (
  input  vl_op_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic          hit,
  output logic [DW-1:0] r1,
  output logic [DW-1:0] r2
);

  localparam int XW = DW + 1;

  function automatic logic [DW-1:0] abs_diff(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic signed [XW-1:0] d;
    d = $signed({x[DW-1], x}) - $signed({y[DW-1], y});
    if (d < 0) d = -d;
    return d[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] abs_val(input logic [DW-1:0] x);
    return x[DW-1] ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [DW-1:0] add_high(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW-1:0] top;
    top = {{(DW-HIW){y[DW-1]}}, y[DW-1 -: HIW]};
    return x + top;
  endfunction

  function automatic logic [DW-1:0] rnd_shift(input logic [DW-1:0] x, input logic [RSW-1:0] n);
    logic signed [XW-1:0] ext;
    logic signed [XW-1:0] acc;
    logic        [XW-1:0] half;
    if (n == '0) return x;
    ext  = $signed({x[DW-1], x});
    half = XW'(1) << (n - 1'b1);
    acc  = ext + $signed(half);
    acc  = acc >>> n;
    return acc[DW-1:0];
  endfunction

  always_comb begin
    hit = 1'b1;
    r1  = '0;
    r2  = '0;
    case (op)
      OP_ADD:    r1 = a + b;
      OP_SUB:    r1 = a - b;
      OP_ADDSUB: begin
        r1 = a + b;
        r2 = a - b;
      end
      OP_ABSDIF: r1 = abs_diff(a, b);
      OP_ABS:    r1 = abs_val(a);
      OP_ADD3:   r1 = a + b + c;
      OP_ADIF3:  r1 = a - b + c;
      OP_SAD:    r1 = c + abs_diff(a, b);
      OP_ADDH:   r1 = add_high(a, b);
      OP_RND:    r1 = rnd_shift(a, b[RSW-1:0]);
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vlane_shift.sv
module vlane_shift
  import vlane_pkg::*;
#(
  parameter int DW  = 40,
  parameter int SHW = 6
) (
  input  vl_op_e         op,
  input  logic [DW-1:0]  a,
  input  logic [SHW-1:0] amt,
  input  logic [DW-1:0]  c,
  output logic           hit,
  output logic [DW-1:0]  r1
);

  localparam int MW = SHW + 1;

  // Sign of amt picks direction; magnitudes past the width saturate
  function automatic logic [DW-1:0] bidir_shift(input logic [DW-1:0] x, input logic [SHW-1:0] k);
    logic [MW-1:0] mag;
    if (!k[SHW-1]) begin
      if (int'(k) >= DW) return '0;
      return x << k;
    end
    mag = MW'(0) - {k[SHW-1], k};
    if (int'(mag) >= DW) return {DW{x[DW-1]}};
    return DW'($signed(x) >>> mag);
  endfunction

  logic [DW-1:0] shifted;
  assign shifted = bidir_shift(a, amt);

  always_comb begin
    hit = 1'b1;
    r1  = '0;
    case (op)
      OP_SHF:   r1 = shifted;
      OP_SHFOR: r1 = c | shifted;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vlane_cmp.sv
module vlane_cmp
  import vlane_pkg::*;
#(
  parameter int DW  = 40,
  parameter int MMW = 33
) (
  input  vl_op_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          hit,
  output logic [DW-1:0] r1,
  output logic [DW-1:0] r2
);

  function automatic logic [DW-1:0] narrow_ext(input logic [DW-1:0] x);
    return {{(DW-MMW){x[MMW-1]}}, x[MMW-1:0]};
  endfunction

  logic [DW-1:0] na, nb, lo, hi;
  logic          a_lt_b_narrow;

  assign na            = narrow_ext(a);
  assign nb            = narrow_ext(b);
  assign a_lt_b_narrow = $signed(na) < $signed(nb);
  assign lo            = a_lt_b_narrow ? na : nb;
  assign hi            = a_lt_b_narrow ? nb : na;

  always_comb begin
    hit = 1'b1;
    r1  = '0;
    r2  = '0;
    case (op)
      OP_CMPEQ: r1 = DW'(a == b);
      OP_CMPGT: r1 = DW'($signed(a) >  $signed(b));
      OP_CMPGE: r1 = DW'($signed(a) >= $signed(b));
      OP_MIN:   r1 = lo;
      OP_MAX:   r1 = hi;
      OP_SORT2: begin
        r1 = lo;
        r2 = hi;
      end
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vlane_logic.sv
module vlane_logic
  import vlane_pkg::*;
#(
  parameter int DW = 40
) (
  input  vl_op_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic          hit,
  output logic [DW-1:0] r1
);

  always_comb begin
    hit = 1'b1;
    r1  = '0;
    case (op)
      OP_AND:  r1 = a & b;
      OP_OR:   r1 = a | b;
      OP_XOR:  r1 = a ^ b;
      OP_ANDN: r1 = a & ~b;
      OP_NOT:  r1 = ~a;
      OP_AND3: r1 = a & b & c;
      OP_OR3:  r1 = a | b | c;
      OP_SEL:  r1 = (a != '0) ? b : c;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vlane_alu.sv
module vlane_alu
  import vlane_pkg::*;
#(
  parameter int DW       = 40,
  parameter int MMW      = 33,
  parameter int SHW      = 6,
  parameter int RSW      = 5,
  parameter int HIW      = 8,
  parameter bit REG_SLOW = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_valid,
  input  logic [4:0]    i_op,
  input  logic [DW-1:0] i_src1,
  input  logic [DW-1:0] i_src2,
  input  logic [DW-1:0] i_src3,
  output logic          o_valid,
  output logic          o_late,
  output logic [DW-1:0] o_dst1,
  output logic [DW-1:0] o_dst2
);

  vl_op_e        op;
  logic          known, slow;
  logic          issue_now;    // zero-slot result shown this cycle
  logic          issue_slow;   // one-slot op captured at the next edge
  logic          ar_hit, sh_hit, cp_hit, lg_hit;
  logic [DW-1:0] ar_r1, ar_r2, sh_r1, cp_r1, cp_r2, lg_r1;
  logic [DW-1:0] res1, res2;
  logic          late_q;
  logic [DW-1:0] hold1_q, hold2_q;
  logic          unit_hit;

  assign op    = vl_op_e'(i_op);
  assign known = op_is_known(op);
  assign slow  = op_is_slow(op);

  vlane_arith #(.DW(DW), .RSW(RSW), .HIW(HIW)) u_arith (
    .op (op), .a (i_src1), .b (i_src2), .c (i_src3),
    .hit(ar_hit), .r1 (ar_r1), .r2 (ar_r2)
  );

  vlane_shift #(.DW(DW), .SHW(SHW)) u_shift (
    .op (op), .a (i_src1), .amt(i_src2[SHW-1:0]), .c (i_src3),
    .hit(sh_hit), .r1 (sh_r1)
  );

  vlane_cmp #(.DW(DW), .MMW(MMW)) u_cmp (
    .op (op), .a (i_src1), .b (i_src2),
    .hit(cp_hit), .r1 (cp_r1), .r2 (cp_r2)
  );

  vlane_logic #(.DW(DW)) u_logic (
    .op (op), .a (i_src1), .b (i_src2), .c (i_src3),
    .hit(lg_hit), .r1 (lg_r1)
  );

  // Units zero their outputs when not selected, so an OR merges them
  assign unit_hit = ar_hit | sh_hit | cp_hit | lg_hit;
  assign res1     = ar_r1 | sh_r1 | cp_r1 | lg_r1;
  assign res2     = ar_r2 | cp_r2;

  generate
    if (REG_SLOW) begin : g_slot
      assign issue_slow = i_valid & known & unit_hit & slow;
      assign issue_now  = i_valid & known & unit_hit & ~slow;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          late_q  <= 1'b0;
          hold1_q <= '0;
          hold2_q <= '0;
        end else begin
          late_q  <= issue_slow;
          hold1_q <= issue_slow ? res1 : '0;
          hold2_q <= issue_slow ? res2 : '0;
        end
      end
    end else begin : g_flat
      assign issue_slow = 1'b0;
      assign issue_now  = i_valid & known & unit_hit;
      assign late_q     = 1'b0;
      assign hold1_q    = '0;
      assign hold2_q    = '0;
    end
  endgenerate

  // A held one-slot result wins over anything issued this cycle
  always_comb begin
    o_valid = 1'b0;
    o_late  = 1'b0;
    o_dst1  = '0;
    o_dst2  = '0;
    if (late_q) begin
      o_valid = 1'b1;
      o_late  = 1'b1;
      o_dst1  = hold1_q;
      o_dst2  = hold2_q;
    end else if (issue_now) begin
      o_valid = 1'b1;
      o_dst1  = res1;
      o_dst2  = res2;
    end
  end

endmodule

// File: rtl/vlane_alu_chk.sv
module vlane_alu_chk
  import vlane_pkg::*;
#(
  parameter int DW       = 40,
  parameter bit REG_SLOW = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          i_valid,
  input logic [4:0]    i_op,
  input logic [DW-1:0] i_src1,
  input logic          o_valid,
  input logic          o_late,
  input logic [DW-1:0] o_dst1,
  input logic [DW-1:0] o_dst2
);

  vl_op_e op;
  logic   live_slow, live_fast;

  assign op        = vl_op_e'(i_op);
  assign live_slow = i_valid && op_is_known(op) && op_is_slow(op) && (REG_SLOW != 0);
  assign live_fast = i_valid && op_is_known(op) && !live_slow;

  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> (o_dst1 == '0 && o_dst2 == '0)) else $error("quiet outputs not zero"); // R11

  AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (live_fast && !o_late && op_is_cmp(op)) |-> (o_valid && o_dst1 <= 1 && o_dst2 == '0)) else $error("compare not 0/1"); // R5

  AST_SORT_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    (live_fast && !o_late && op == OP_SORT2) |-> ($signed(o_dst1) <= $signed(o_dst2))) else $error("sort pair out of order"); // R6

  AST_PAIR_SUMS: assert property (@(posedge clk) disable iff (!rst_n)
    (live_fast && !o_late && op == OP_ADDSUB) |-> (DW'(o_dst1 + o_dst2) == DW'(i_src1 << 1))) else $error("add/sub pair inconsistent"); // R1

  AST_FAST_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (live_fast && !o_late) |-> o_valid) else $error("zero-slot result missing"); // R9

  generate
    if (REG_SLOW) begin : g_slot_chk
      AST_SLOT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        live_slow |=> (o_valid && o_late)) else $error("one-slot result not due"); // R9

      AST_LATE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        o_late |-> $past(live_slow)) else $error("late flag without cause"); // R10
    end else begin : g_flat_chk
      AST_NEVER_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        !o_late) else $error("late flag in flat mode"); // R9
    end
  endgenerate

endmodule

bind vlane_alu vlane_alu_chk #(.DW(DW), .REG_SLOW(REG_SLOW)) u_vlane_alu_chk (
  .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_op(i_op), .i_src1(i_src1),
  .o_valid(o_valid), .o_late(o_late), .o_dst1(o_dst1), .o_dst2(o_dst2)
);

// File: tb/vlane_alu_bench.sv
module vlane_alu_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_valid = 1'b0;
  logic [4:0]  i_op = '0;
  logic [39:0] i_src1 = '0, i_src2 = '0, i_src3 = '0;
  logic        o_valid, o_late;
  logic [39:0] o_dst1, o_dst2;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlane_alu u_vlane_alu (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_op(i_op),
    .i_src1(i_src1), .i_src2(i_src2), .i_src3(i_src3),
    .o_valid(o_valid), .o_late(o_late), .o_dst1(o_dst1), .o_dst2(o_dst2)
  );

  function automatic longint sx40(input logic [39:0] x);
    return longint'({{24{x[39]}}, x});
  endfunction

  function automatic longint sx33(input logic [39:0] x);
    return longint'({{31{x[32]}}, x[32:0]});
  endfunction

  function automatic bit is_slow(input logic [4:0] op);
    return op inside {5'd12, 5'd16, 5'd17, 5'd18, 5'd20, 5'd21, 5'd22};
  endfunction

  function automatic string req_of(input logic [4:0] op);
    case (op)
      1, 2, 24:             return "R1";
      3, 16, 17, 18, 25, 26: return "R2";
      4, 5, 6, 7, 8, 20, 21: return "R3";
      19:                   return "R4";
      13, 14, 15:           return "R5";
      9, 10, 23:            return "R6";
      11, 22:               return "R7";
      12:                   return "R8";
      default:              return "R11";
    endcase
  endfunction

  function automatic longint shf_model(input logic [39:0] a, input logic [5:0] k);
    int s;
    s = int'($signed(k));
    if (s >= 0) return (s >= 40) ? 64'sd0 : (sx40(a) << s);
    if (-s >= 40) return a[39] ? -64'sd1 : 64'sd0;
    return sx40(a) >>> (-s);
  endfunction

  function automatic longint iabs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model(input logic [4:0] op, input logic [39:0] a, b, c,
                       output bit v, output logic [39:0] d1, output logic [39:0] d2);
    longint x1, x2;
    int n;
    x1 = 0; x2 = 0; v = 1'b1;
    case (op)
      1:  x1 = sx40(a) + sx40(b);
      2:  x1 = sx40(a) - sx40(b);
      24: begin x1 = sx40(a) + sx40(b); x2 = sx40(a) - sx40(b); end
      3:  x1 = iabs(sx40(a) - sx40(b));
      26: x1 = iabs(sx40(a));
      16: x1 = sx40(a) + sx40(b) + sx40(c);
      17: x1 = sx40(a) - sx40(b) + sx40(c);
      18: x1 = sx40(c) + iabs(sx40(a) - sx40(b));
      25: x1 = sx40(a) + longint'($signed(b[39:32]));
      4:  x1 = sx40(a & b);
      5:  x1 = sx40(a | b);
      6:  x1 = sx40(a ^ b);
      7:  x1 = sx40(a & ~b);
      8:  x1 = sx40(~a);
      20: x1 = sx40(a & b & c);
      21: x1 = sx40(a | b | c);
      19: x1 = (a != 0) ? sx40(b) : sx40(c);
      13: x1 = (a == b) ? 1 : 0;
      14: x1 = (sx40(a) > sx40(b)) ? 1 : 0;
      15: x1 = (sx40(a) >= sx40(b)) ? 1 : 0;
      9:  x1 = (sx33(a) < sx33(b)) ? sx33(a) : sx33(b);
      10: x1 = (sx33(a) > sx33(b)) ? sx33(a) : sx33(b);
      23: begin
        x1 = (sx33(a) < sx33(b)) ? sx33(a) : sx33(b);
        x2 = (sx33(a) < sx33(b)) ? sx33(b) : sx33(a);
      end
      11: x1 = shf_model(a, b[5:0]);
      22: x1 = sx40(c) | shf_model(a, b[5:0]);
      12: begin
        n = int'(b[4:0]);
        x1 = (n == 0) ? sx40(a) : ((sx40(a) + (64'sd1 <<< (n - 1))) >>> n);
      end
      default: v = 1'b0;
    endcase
    d1 = x1[39:0];
    d2 = x2[39:0];
  endtask

  task automatic check(input string tag, input bit ev, input bit el,
                       input logic [39:0] e1, input logic [39:0] e2);
    vectors++;
    if (o_valid !== ev || o_late !== el || o_dst1 !== e1 || o_dst2 !== e2) begin
      misses++;
      $display("FAIL %s: got valid=%0b late=%0b d1=%h d2=%h, expected valid=%0b late=%0b d1=%h d2=%h",
               tag, o_valid, o_late, o_dst1, o_dst2, ev, el, e1, e2);
    end
  endtask

  // Issue one op and check it where its result is due
  task automatic run_op(input logic [4:0] op, input logic [39:0] a, b, c);
    bit v;
    logic [39:0] e1, e2;
    model(op, a, b, c, v, e1, e2);
    @(negedge clk);
    i_valid = 1'b1; i_op = op; i_src1 = a; i_src2 = b; i_src3 = c;
    if (v && is_slow(op)) begin
      @(negedge clk);
      i_valid = 1'b0; i_op = 5'($urandom); i_src1 = {$urandom, $urandom}; i_src2 = {$urandom, $urandom};
      #1 check({req_of(op), " R9"}, 1'b1, 1'b1, e1, e2);
    end else begin
      #1 check(req_of(op), v, 1'b0, e1, e2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL R9: watchdog expired, got no finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    bit v;
    logic [39:0] e1, e2, a, b, c;
    logic [4:0] op;

    // R11: reset state
    repeat (2) @(negedge clk);
    i_valid = 1'b1; i_op = 5'd16; i_src1 = 40'h5;
    #1 check("R11 reset", 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    i_valid = 1'b0;
    rst_n = 1'b1;

    // Directed corners
    run_op(5'd1, 40'h7F_FFFF_FFFF, 40'h1, 40'h0);              // R1 wrap
    run_op(5'd24, 40'h10, 40'h30, 40'h0);                      // R1 pair
    run_op(5'd26, 40'h80_0000_0000, 40'h0, 40'h0);             // R2 abs of most negative
    run_op(5'd3, 40'h80_0000_0000, 40'h7F_FFFF_FFFF, 40'h0);   // R2 absdif wide
    run_op(5'd25, 40'h100, 40'hFF_0000_0000, 40'h0);           // R2 top byte -1
    run_op(5'd19, 40'h0, 40'hAAAA, 40'h5555);                  // R4 zero selector
    run_op(5'd19, 40'h10_0000_0000, 40'hAAAA, 40'h5555);       // R4 high bit selector
    run_op(5'd14, 40'h80_0000_0000, 40'h1, 40'h0);             // R5 signed
    run_op(5'd15, 40'h3, 40'h3, 40'h0);                        // R5 equal
    run_op(5'd23, 40'h1_0000_0000, 40'h5, 40'h0);              // R6 bit32 negative
    run_op(5'd11, 40'h80_0000_0001, 40'h20, 40'h0);            // R7 right by 32
    run_op(5'd11, 40'h00_0000_0003, 40'h1F, 40'h0);            // R7 left by 31
    run_op(5'd22, 40'hF0, 40'h3C, 40'h1);                      // R7 shift-or, right 4
    run_op(5'd12, 40'hFF_FFFF_FFFD, 40'h1, 40'h0);             // R8 -3 rounds to -1
    run_op(5'd12, 40'h1234, 40'h0, 40'h0);                     // R8 n=0
    run_op(5'd12, 40'h7F_FFFF_FFFF, 40'h4, 40'h0);             // R8 no overflow
    run_op(5'd20, 40'hFF, 40'h0F, 40'h3C);                     // R3 and3
    run_op(5'd0, 40'h1, 40'h2, 40'h3);                         // R11 nop
    run_op(5'd29, 40'h1, 40'h2, 40'h3);                        // R11 undefined

    // R11: valid low gives no output
    @(negedge clk);
    i_valid = 1'b0; i_op = 5'd1; i_src1 = 40'h9; i_src2 = 40'h9;
    #1 check("R11 idle", 1'b0, 1'b0, '0, '0);

    // R10: one-slot result collides with a zero-slot op issued next cycle
    model(5'd16, 40'h1, 40'h2, 40'h3, v, e1, e2);
    @(negedge clk);
    i_valid = 1'b1; i_op = 5'd16; i_src1 = 40'h1; i_src2 = 40'h2; i_src3 = 40'h3;
    @(negedge clk);
    i_op = 5'd1; i_src1 = 40'h100; i_src2 = 40'h200;
    #1 check("R10 precedence", 1'b1, 1'b1, e1, e2);
    @(negedge clk);
    i_valid = 1'b0;
    #1 check("R10 dropped", 1'b0, 1'b0, '0, '0);

    // Constrained random with a fixed seed
    void'($urandom(32'h5EED_0A1F));
    for (int i = 0; i < 3000; i++) begin
      op = 5'($urandom);
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      c  = {$urandom, $urandom};
      case ($urandom % 4)
        0: b = a;
        1: begin a = 40'($signed(6'($urandom))); b = 40'($urandom % 64); end
        default: ;
      endcase
      run_op(op, a, b, c);
    end

    @(negedge clk);
    i_valid = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule